// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it takes the accumulator value, a second byte and an operation code, and it combinationally produces the byte that the datapath writes back into the first operand. The carry, half-carry (carry between the two nibbles) and signed-overflow flags are held in registers inside the block. The carry register also feeds the carry-consuming operations.

The operation set covers add, add with carry, subtract with borrow, increment, decrement, decimal adjust after a packed-BCD add, bitwise AND/OR/XOR, clear, complement, nibble swap, and four rotates. Two of the rotates run through the carry flag. Flags change only on a rising clock edge when `op_en` is high, and only the flags that the selected operation defines are touched.

Top module: `acc_alu`

## Requirements
- R1: With op_code 0 (add), result_o = (acc_in + opnd_in) mod 256. When op_en is high, the next edge loads cy_o with the carry out of bit 7, ac_o with the carry out of bit 3, and ov_o with two's-complement overflow.
- R2: With op_code 1 (add with carry), the current cy_o is added as a third input. The result and all three flags are defined as in R1.
- R3: With op_code 2 (subtract with borrow), result_o = (acc_in - opnd_in - cy_o) mod 256. cy_o is set when a borrow into bit 7 occurs, ac_o when a borrow into bit 3 occurs, and ov_o on signed overflow.
- R4: Op_code 3 gives acc_in + 1 and op_code 4 gives acc_in - 1, both wrapping modulo 256. Both leave all three flags unchanged.
- R5: Op_codes 6, 7 and 8 give the bitwise AND, OR and XOR of acc_in and opnd_in. All three flags stay unchanged.
- R6: Op_code 9 gives 0x00 and op_code 10 gives the bitwise inverse of acc_in. Flags stay unchanged.
- R7: Op_code 11 exchanges the upper and lower nibbles of acc_in. Flags stay unchanged.
- R8: Op_code 12 rotates acc_in left by one bit, with bit 7 going to bit 0. Op_code 13 rotates it right by one bit, with bit 0 going to bit 7. Flags stay unchanged.
- R9: Op_code 14 shifts acc_in left, with cy_o entering bit 0, and the next carry is the old bit 7. Op_code 15 shifts it right, with cy_o entering bit 7, and the next carry is the old bit 0. ac_o and ov_o stay unchanged.
- R10: For op_code 5 (decimal adjust), 0x06 is added when the low nibble exceeds 9 or ac_o is set. Then 0x60 is added when the resulting high nibble exceeds 9 or the carry (including any carry from the first step) is set.
- R11: Decimal adjust sets cy_o when either adjustment step carries out of bit 7. It never clears cy_o, and it leaves ac_o and ov_o unchanged.
- R12: When op_en is low, no flag changes. A synchronous active-high rst clears all three flags to 0.
- R13: result_o depends only on the present acc_in, opnd_in, op_code and flag state, independent of op_en, and is valid within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_en | input | 1 | Commit the operation's flag updates at the next edge |
| op_code | input | 4 | Operation select, encodings as in the requirements |
| acc_in | input | 8 | Accumulator (first operand) |
| opnd_in | input | 8 | Second operand |
| result_o | output | 8 | Combinational result for write-back |
| cy_o | output | 1 | Registered carry / borrow flag |
| ac_o | output | 1 | Registered half-carry flag |
| ov_o | output | 1 | Registered signed-overflow flag |

## Verification
The hardest states to reach are the decimal-adjust cases, because they depend on flag values left behind by earlier operations. These include a half-carry that is set while the low nibble is 9 or less, and a carry that is already set before an adjust that would not overflow by itself.

The stimulus builds these states on purpose:
- It runs BCD adds that generate a half-carry or a carry, and follows each with an adjust.
- It sets carry with an overflowing add, then runs an adjust on a value that needs no correction.
- It chains rotates through carry, so the carry ring is exercised across several operations.
- It issues operations with op_en low, to confirm that the flags hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW = 8;
    localparam int NW = DW / 2;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_DA   = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_CLR  = 4'd9,
        OP_CPL  = 4'd10,
        OP_SWAP = 4'd11,
        OP_RL   = 4'd12,
        OP_RR   = 4'd13,
        OP_RLC  = 4'd14,
        OP_RRC  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic ov;
        logic ac;
        logic cy;
    } flags_t;

    localparam int FW = $bits(flags_t);

    // Which flags an operation is allowed to write.
    function automatic flags_t upd_mask(input alu_op_e op);
        flags_t m;
        m = '0;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUBB: m = '{ov: 1'b1, ac: 1'b1, cy: 1'b1};
            OP_DA, OP_RLC, OP_RRC:    m = '{ov: 1'b0, ac: 1'b0, cy: 1'b1};
            default:                  m = '0;
        endcase
        return m;
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB) ||
               (op == OP_INC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
    import acc_alu_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             cin,
    output logic [DW-1:0]    res,
    output flags_t           fl
);
    logic          sub;
    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic [DW:0]   sum;
    logic [NW:0]   nsum;

    // One adder serves all five operations; subtract uses a + ~b + ~cin.
    always_comb begin
        sub   = (op == OP_SUBB);
        b_eff = b;
        c_eff = 1'b0;
        unique case (op)
            OP_ADDC: c_eff = cin;
            OP_SUBB: begin b_eff = ~b;  c_eff = ~cin; end
            OP_INC:  begin b_eff = '0;  c_eff = 1'b1; end
            OP_DEC:  begin b_eff = '1;  c_eff = 1'b0; end
            default: ;
        endcase
        sum  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
        nsum = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
        res   = sum[DW-1:0];
        fl.cy = sum[DW] ^ sub;
        fl.ac = nsum[NW] ^ sub;
        fl.ov = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             cin,
    output logic [DW-1:0]    res,
    output logic             cout
);
    always_comb begin
        res  = '0;
        cout = cin;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CLR:  res = '0;
            OP_CPL:  res = ~a;
            OP_SWAP: res = {a[NW-1:0], a[DW-1:NW]};
            OP_RL:   res = {a[DW-2:0], a[DW-1]};
            OP_RR:   res = {a[0], a[DW-1:1]};
            OP_RLC:  begin res = {a[DW-2:0], cin}; cout = a[DW-1]; end
            OP_RRC:  begin res = {cin, a[DW-1:1]}; cout = a[0];    end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0]    a,
    input  logic             cin,
    input  logic             acin,
    output logic [DW-1:0]    res,
    output logic             cout
);
    localparam logic [DW:0] LO_FIX = (DW+1)'(6);
    localparam logic [DW:0] HI_FIX = (DW+1)'(8'h60);
    localparam logic [NW-1:0] DIGIT_MAX = NW'(9);

    logic [DW:0] stage1;
    logic [DW:0] stage2;
    logic        c1;

    always_comb begin
        stage1 = {1'b0, a} +
                 (((a[NW-1:0] > DIGIT_MAX) || acin) ? LO_FIX : '0);
        c1     = cin | stage1[DW];
        stage2 = {1'b0, stage1[DW-1:0]} +
                 (((stage1[DW-1:NW] > DIGIT_MAX) || c1) ? HI_FIX : '0);
        res    = stage2[DW-1:0];
        cout   = c1 | stage2[DW];
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_en,
    input  logic [3:0]    op_code,
    input  logic [7:0]    acc_in,
    input  logic [7:0]    opnd_in,
    output logic [7:0]    result_o,
    output logic          cy_o,
    output logic          ac_o,
    output logic          ov_o
);
    alu_op_e       op;
    flags_t        fl_q;
    flags_t        fl_new;
    flags_t        fl_mask;
    flags_t        as_fl;
    logic [DW-1:0] as_res, bo_res, da_res;
    logic          bo_cy, da_cy;

    assign op = alu_op_e'(op_code);

    acc_alu_addsub u_addsub (
        .op(op), .a(acc_in), .b(opnd_in), .cin(fl_q.cy),
        .res(as_res), .fl(as_fl)
    );

    acc_alu_bitops u_bitops (
        .op(op), .a(acc_in), .b(opnd_in), .cin(fl_q.cy),
        .res(bo_res), .cout(bo_cy)
    );

    acc_alu_decadj u_decadj (
        .a(acc_in), .cin(fl_q.cy), .acin(fl_q.ac),
        .res(da_res), .cout(da_cy)
    );

    always_comb begin
        fl_mask = upd_mask(op);
        if (is_arith(op)) begin
            result_o = as_res;
            fl_new   = as_fl;
        end else if (op == OP_DA) begin
            result_o = da_res;
            fl_new   = '{ov: fl_q.ov, ac: fl_q.ac, cy: da_cy};
        end else begin
            result_o = bo_res;
            fl_new   = '{ov: fl_q.ov, ac: fl_q.ac, cy: bo_cy};
        end
    end

    // One flop per flag bit, each gated by its own update-mask bit.
    for (genvar i = 0; i < FW; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                fl_q[i] <= 1'b0;
            else if (op_en && fl_mask[i])
                fl_q[i] <= fl_new[i];
        end
    end

    assign cy_o = fl_q.cy;
    assign ac_o = fl_q.ac;
    assign ov_o = fl_q.ov;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       op_en,
    input logic [3:0] op_code,
    input logic [7:0] acc_in,
    input logic [7:0] opnd_in,
    input logic [7:0] result_o,
    input logic       cy_o,
    input logic       ac_o,
    input logic       ov_o
);
    logic keep_all;
    assign keep_all = (op_code == OP_INC) || (op_code == OP_DEC) ||
                      (op_code == OP_AND) || (op_code == OP_OR)  ||
                      (op_code == OP_XOR) || (op_code == OP_CLR) ||
                      (op_code == OP_CPL) || (op_code == OP_SWAP) ||
                      (op_code == OP_RL)  || (op_code == OP_RR);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> ({ov_o, ac_o, cy_o} == 3'b000)); // R12

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op_en |=> $stable({ov_o, ac_o, cy_o})); // R12

    AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (op_en && keep_all) |=> $stable({ov_o, ac_o, cy_o})); // R5

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_CLR) |-> (result_o == 8'h00)); // R6

    AST_RLC_RING: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code == OP_RLC) |=>
            (cy_o == $past(acc_in[7]) && $stable({ov_o, ac_o}))); // R9

    AST_DA_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code == OP_DA && cy_o) |=> cy_o); // R11

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_ADD) |-> (result_o == 8'(acc_in + opnd_in))); // R1
endmodule

bind acc_alu acc_alu_chk chk_i (
    .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .result_o(result_o),
    .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_en = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] opnd_in = 8'd0;
    logic [7:0] result_o;
    logic       cy_o, ac_o, ov_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu dut_i (
        .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .result_o(result_o),
        .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
    );

    typedef struct {
        logic [7:0] r;
        logic [2:0] f;   // {ov, ac, cy} after the edge
        string      tag;
    } item_t;

    item_t sbq[$];
    int mcy = 0, mac = 0, mov = 0;

    function automatic string req_of(input int op);
        case (op)
            0: return "R1";  1: return "R2";  2: return "R3";
            3, 4: return "R4";  5: return "R10";
            6, 7, 8: return "R5";  9, 10: return "R6";
            11: return "R7";  12, 13: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // Reference model: returns {ov, ac, cy, result}
    function automatic logic [10:0] model(input int op, input int a, input int b);
        int r, c, h, o, s, cin, t;
        r = 0; c = mcy; h = mac; o = mov;
        case (op)
            0, 1: begin
                cin = (op == 1) ? mcy : 0;
                s = a + b + cin;  r = s & 255;  c = (s > 255);
                h = (((a & 15) + (b & 15) + cin) > 15);
                s = sx(a) + sx(b) + cin;  o = (s > 127 || s < -128);
            end
            2: begin
                s = a - b - mcy;  r = s & 255;  c = (s < 0);
                h = (((a & 15) - (b & 15) - mcy) < 0);
                s = sx(a) - sx(b) - mcy;  o = (s > 127 || s < -128);
            end
            3: r = (a + 1) & 255;
            4: r = (a + 255) & 255;
            5: begin
                t = a;
                if ((t & 15) > 9 || mac != 0) t = t + 6;
                if (t > 255) c = 1;
                t = t & 255;
                if (((t >> 4) & 15) > 9 || c != 0) t = t + 'h60;
                if (t > 255) c = 1;
                r = t & 255;
            end
            6: r = a & b;
            7: r = a | b;
            8: r = a ^ b;
            9: r = 0;
            10: r = (~a) & 255;
            11: r = ((a << 4) | (a >> 4)) & 255;
            12: r = ((a << 1) | (a >> 7)) & 255;
            13: r = (a >> 1) | ((a & 1) << 7);
            14: begin r = ((a << 1) & 255) | mcy; c = a >> 7; end
            default: begin r = (a >> 1) | (mcy << 7); c = a & 1; end
        endcase
        return {o[0], h[0], c[0], r[7:0]};
    endfunction

    task automatic drive(input int op, input int a, input int b, input bit en);
        logic [10:0] m;
        item_t it;
        @(negedge clk);
        op_code = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; op_en = en;
        m = model(op, a, b);
        it.r = m[7:0];
        it.tag = req_of(op);
        if (en) begin
            it.f = m[10:8];
            mov = m[10]; mac = m[9]; mcy = m[8];
        end else begin
            it.f = {mov[0], mac[0], mcy[0]};
            it.tag = "R12";
        end
        sbq.push_back(it);
    endtask

    // Monitor: result before the edge, flags after it.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                checks++;
                if (result_o !== it.r) begin
                    errors++;
                    $display("FAIL %s/R13 result actual=%h expected=%h", it.tag, result_o, it.r);
                end
                @(posedge clk);
                #1;
                checks++;
                if ({ov_o, ac_o, cy_o} !== it.f) begin
                    errors++;
                    $display("FAIL %s flags actual=%b expected=%b", it.tag, {ov_o, ac_o, cy_o}, it.f);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if ({ov_o, ac_o, cy_o} !== 3'b000) begin
            errors++;
            $display("FAIL R12 reset flags actual=%b expected=000", {ov_o, ac_o, cy_o});
        end
        // R1 add corners
        drive(0, 8'h0F, 8'h01, 1);
        drive(0, 8'h7F, 8'h01, 1);
        drive(0, 8'hFF, 8'h01, 1);
        // R2 add with carry (carry set from previous)
        drive(1, 8'h10, 8'h20, 1);
        drive(0, 8'hFF, 8'h01, 1);
        drive(1, 8'h0E, 8'h01, 1);
        // R3 subtract with borrow
        drive(2, 8'h00, 8'h01, 1);
        drive(2, 8'h10, 8'h01, 1);
        drive(2, 8'h80, 8'h01, 1);
        drive(2, 8'h55, 8'h55, 1);
        // R12 disabled commit
        drive(0, 8'hFF, 8'hFF, 0);
        // R4 inc/dec wrap, flags held
        drive(0, 8'hFF, 8'h01, 1);
        drive(3, 8'hFF, 8'h00, 1);
        drive(4, 8'h00, 8'h00, 1);
        // R5 R6 R7 R8 logic and moves
        drive(6, 8'hF0, 8'h3C, 1);
        drive(7, 8'hF0, 8'h0C, 1);
        drive(8, 8'hAA, 8'hFF, 1);
        drive(9, 8'hA5, 8'h00, 1);
        drive(10, 8'hA5, 8'h00, 1);
        drive(11, 8'h1E, 8'h00, 1);
        drive(12, 8'h81, 8'h00, 1);
        drive(13, 8'h81, 8'h00, 1);
        // R9 carry ring
        drive(14, 8'h80, 8'h00, 1);
        drive(14, 8'h01, 8'h00, 1);
        drive(15, 8'h01, 8'h00, 1);
        drive(15, 8'h00, 8'h00, 1);
        // R10 decimal adjust
        drive(0, 8'h19, 8'h28, 1);
        drive(5, 8'h41, 8'h00, 1);
        drive(0, 8'h99, 8'h01, 1);
        drive(5, 8'h9A, 8'h00, 1);
        drive(0, 8'h55, 8'h55, 1);
        drive(5, 8'hAA, 8'h00, 1);
        // R11 carry already set, no adjust needed: must stay set
        drive(0, 8'h90, 8'h90, 1);
        drive(5, 8'h20, 8'h00, 1);
        drive(5, 8'h12, 8'h00, 1);
        // Mixed sweep over all operations
        seed = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            int a, b;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            a = seed & 255; b = (seed >> 8) & 255;
            drive(i % 16, a, b, ((seed >> 20) & 7) != 0);
        end
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule